// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Tracker

This block sits beside the decode stage of a simple in-order core and enforces landing pads for indirect branches. Each cycle the decoder may present one instruction descriptor. The descriptor says whether the instruction is a tracked indirect branch, an indirect branch marked as untracked, a landing-pad marker for 32-bit or 64-bit mode, or anything else. The block keeps one "expecting a landing pad" bit per privilege level. When the bit for the running level is set and the next instruction is not the right landing pad, the block reports a control-protection fault and blocks that instruction from retiring.

Event delivery (an interrupt, exception or fault) forces the supervisor bit on, so the handler's first instruction must itself be a landing pad. At delivery the interrupted level's bit is copied into a saved-frame bit. When the interrupted level was user, the bit is also copied into a per-user save register. Two return styles follow delivery. A legacy return leaves the resumed level's bit clear. A frame-based return reloads the bit from the saved frame. Handler software can clear the saved-frame bit through a dedicated input, so that a faulting instruction is not simply faulted again.

Top module: `lpad_tracker`

## Requirements
- R1: After synchronous reset, every tracking bit, the saved-frame bit and the per-user save bit are 0, and no result is reported.
- R2: An accepted instruction of kind 1 (tracked indirect branch), seen while the current level's bit is clear, retires and sets that level's bit. The result appears one cycle after the instruction.
- R3: An instruction seen while the current level's bit is clear, other than kind 1, retires and leaves the bit at 0. A correct landing pad seen while the bit is set retires and clears it, so the bit survives exactly one instruction boundary.
- R4: Kind 2 (indirect branch with the untracked marker) retires and leaves the current level's bit at 0.
- R5: While the current level's bit is set, a non-landing-pad instruction reports a fault with kind code 1 (missing pad). It does not retire, and the bit stays set.
- R6: While the bit is set, a landing pad of the wrong width reports fault kind code 2 and does not retire. Kind 3 is the 32-bit pad, expected when mode64 is 0. Kind 4 is the 64-bit pad, expected when mode64 is 1.
- R7: Event delivery sets the supervisor bit (level 1) and copies the current level's bit into the saved-frame bit. When the current level is user (level 0), it also copies the user bit into the per-user save bit. An instruction offered in the same cycle is dropped and produces no result.
- R8: A legacy return sets the target level's bit to 0, whatever the saved-frame bit holds.
- R9: A frame-based return loads the target level's bit from the saved-frame bit. A restored 1 makes the resumed non-pad instruction fault again.
- R10: The frame-clear input clears the saved-frame bit. When it coincides with event delivery, the delivery's copy wins.
- R11: Instructions update only the bit of the current level. The bit of the other level keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | A decoded descriptor is offered this cycle |
| insn_kind | input | 3 | 0 other, 1 tracked indirect branch, 2 untracked indirect branch, 3 pad-32, 4 pad-64 |
| mode64 | input | 1 | 1 when the core runs in 64-bit mode |
| cur_lvl | input | 1 | Current privilege level: 0 user, 1 supervisor |
| evt_deliver | input | 1 | Event delivery into the supervisor handler |
| ret_legacy | input | 1 | Legacy return to level ret_lvl |
| ret_frame | input | 1 | Frame-based return to level ret_lvl |
| ret_lvl | input | 1 | Level resumed by a return |
| frame_clr | input | 1 | Software clear of the saved-frame bit |
| res_valid | output | 1 | Verdict for the instruction accepted one cycle earlier |
| res_retire | output | 1 | That instruction retires |
| res_fault | output | 1 | Control-protection fault raised |
| res_kind | output | 2 | 0 none, 1 missing pad, 2 wrong-width pad |
| wait_bits | output | 2 | Tracking bit per level, bit index = level |
| frame_bit | output | 1 | Tracking bit held in the saved frame |
| user_save | output | 1 | Per-user saved tracking bit |

## Verification
The hardest state to reach is the refault loop. It needs a tracked branch, a faulting non-pad instruction, then a delivery that captures the set bit, a handler landing pad, and finally a frame-based return that reloads the bit so the same instruction faults again. The stimulus steps through that whole sequence twice: once letting the loop recur, and once clearing the saved-frame bit inside the handler so the resumed instruction retires. A second awkward case is delivery arriving from user level in the same cycle as a branch. The scoreboard flags any verdict that arrives with no expected item queued, which shows that the dropped instruction left no trace.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [2:0] {
        K_OTHER  = 3'd0,
        K_IND    = 3'd1,
        K_IND_NT = 3'd2,
        K_PAD32  = 3'd3,
        K_PAD64  = 3'd4
    } insn_kind_e;

    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_MISSING = 2'd1,
        FK_WIDTH   = 2'd2
    } fault_kind_e;

    typedef struct packed {
        logic        retire;
        logic        fault;
        fault_kind_e kind;
        logic        next_wait;
    } verdict_t;

    function automatic logic is_pad(insn_kind_e k);
        return (k == K_PAD32) || (k == K_PAD64);
    endfunction

    function automatic insn_kind_e pad_for_mode(logic m64);
        return m64 ? K_PAD64 : K_PAD32;
    endfunction

endpackage

// File: rtl/lpt_check.sv
module lpt_check
    import lpt_pkg::*;
(
    input  insn_kind_e kind,
    input  logic       mode64,
    input  logic       wait_cur,
    output verdict_t   verdict
);
    always_comb begin
        verdict      = '0;
        verdict.kind = FK_NONE;
        if (wait_cur) begin
            if (kind == pad_for_mode(mode64)) begin
                verdict.retire    = 1'b1;
                verdict.next_wait = 1'b0;
            end else begin
                verdict.fault     = 1'b1;
                verdict.next_wait = 1'b1;
                verdict.kind      = is_pad(kind) ? FK_WIDTH : FK_MISSING;
            end
        end else begin
            verdict.retire    = 1'b1;
            verdict.next_wait = (kind == K_IND);
        end
    end
endmodule

// File: rtl/lpt_wait_bank.sv
module lpt_wait_bank #(
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = $clog2(NUM_LVL),
    parameter int SUP_LVL = NUM_LVL - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic               ret_any,
    input  logic               ret_frame,
    input  logic [LVL_W-1:0]   ret_lvl,
    input  logic               frame_bit,
    input  logic               insn_go,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               next_wait,
    output logic [NUM_LVL-1:0] wait_q
);
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        logic lvl_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= 1'b0;
            end else if (evt) begin
                if (i == SUP_LVL) lvl_q <= 1'b1;
            end else if (ret_any) begin
                if (LVL_W'(i) == ret_lvl) lvl_q <= ret_frame ? frame_bit : 1'b0;
                else if (i == SUP_LVL)    lvl_q <= 1'b0;
            end else if (insn_go && (LVL_W'(i) == cur_lvl)) begin
                lvl_q <= next_wait;
            end
        end
        assign wait_q[i] = lvl_q;
    end
endmodule

// File: rtl/lpt_frame.sv
module lpt_frame #(
    parameter int NUM_LVL  = 2,
    parameter int LVL_W    = $clog2(NUM_LVL),
    parameter int USER_LVL = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic               frame_clr,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic [NUM_LVL-1:0] wait_q,
    output logic               frame_bit,
    output logic               user_save
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_bit <= 1'b0;
            user_save <= 1'b0;
        end else if (evt) begin
            frame_bit <= wait_q[cur_lvl];
            if (cur_lvl == LVL_W'(USER_LVL)) user_save <= wait_q[USER_LVL];
        end else if (frame_clr) begin
            frame_bit <= 1'b0;
        end
    end
endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
    import lpt_pkg::*;
#(
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = $clog2(NUM_LVL),
    parameter int KIND_W  = 3,
    parameter int FK_W    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               insn_valid,
    input  logic [KIND_W-1:0]  insn_kind,
    input  logic               mode64,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               evt_deliver,
    input  logic               ret_legacy,
    input  logic               ret_frame,
    input  logic [LVL_W-1:0]   ret_lvl,
    input  logic               frame_clr,
    output logic               res_valid,
    output logic               res_retire,
    output logic               res_fault,
    output logic [FK_W-1:0]    res_kind,
    output logic [NUM_LVL-1:0] wait_bits,
    output logic               frame_bit,
    output logic               user_save
);
    localparam int SUP_LVL  = NUM_LVL - 1;
    localparam int USER_LVL = 0;

    logic     ret_any;
    logic     insn_go;
    logic     wait_cur;
    verdict_t verdict;

    assign ret_any  = ret_legacy | ret_frame;
    assign insn_go  = insn_valid & ~evt_deliver & ~ret_any;
    assign wait_cur = wait_bits[cur_lvl];

    lpt_check u_check (
        .kind     (insn_kind_e'(insn_kind)),
        .mode64   (mode64),
        .wait_cur (wait_cur),
        .verdict  (verdict)
    );

    lpt_wait_bank #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .SUP_LVL(SUP_LVL)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_deliver),
        .ret_any   (ret_any),
        .ret_frame (ret_frame),
        .ret_lvl   (ret_lvl),
        .frame_bit (frame_bit),
        .insn_go   (insn_go),
        .cur_lvl   (cur_lvl),
        .next_wait (verdict.next_wait),
        .wait_q    (wait_bits)
    );

    lpt_frame #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .USER_LVL(USER_LVL)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_deliver),
        .frame_clr (frame_clr),
        .cur_lvl   (cur_lvl),
        .wait_q    (wait_bits),
        .frame_bit (frame_bit),
        .user_save (user_save)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_retire <= 1'b0;
            res_fault  <= 1'b0;
            res_kind   <= '0;
        end else begin
            res_valid  <= insn_go;
            res_retire <= insn_go & verdict.retire;
            res_fault  <= insn_go & verdict.fault;
            res_kind   <= insn_go ? FK_W'(verdict.kind) : '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && wait_bits == '0));

    assert_branch_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (insn_go && !wait_cur && insn_kind_e'(insn_kind) == K_IND)
        |=> (wait_bits[$past(cur_lvl)] && res_retire));

    assert_one_shot_R3: assert property (@(posedge clk) disable iff (rst)
        (insn_go && wait_cur) |=> (res_fault || !wait_bits[$past(cur_lvl)]));

    assert_untracked_R4: assert property (@(posedge clk) disable iff (rst)
        (insn_go && !wait_cur && insn_kind_e'(insn_kind) == K_IND_NT)
        |=> (!wait_bits[$past(cur_lvl)] && res_retire));

    assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> (!res_retire && res_kind != '0 && wait_bits[$past(cur_lvl)]));

    assert_event_arms_R7: assert property (@(posedge clk) disable iff (rst)
        evt_deliver |=> (wait_bits[SUP_LVL] && !res_valid));

    assert_legacy_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_legacy && !ret_frame && !evt_deliver) |=> !wait_bits[$past(ret_lvl)]);

    assert_frame_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_frame && !evt_deliver) |=> (wait_bits[$past(ret_lvl)] == $past(frame_bit)));

    assert_frame_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_clr && !evt_deliver) |=> !frame_bit);
endmodule

// File: tb/lpad_tracker_tb.sv
`timescale 1ns/1ps
module lpad_tracker_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       insn_valid = 1'b0;
    logic [2:0] insn_kind = 3'd0;
    logic       mode64 = 1'b1;
    logic       cur_lvl = 1'b1;
    logic       evt_deliver = 1'b0;
    logic       ret_legacy = 1'b0;
    logic       ret_frame = 1'b0;
    logic       ret_lvl = 1'b0;
    logic       frame_clr = 1'b0;
    logic       res_valid, res_retire, res_fault, user_save, frame_bit;
    logic [1:0] res_kind, wait_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       retire;
        logic       fault;
        logic [1:0] kind;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lpad_tracker u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_kind(insn_kind),
        .mode64(mode64), .cur_lvl(cur_lvl), .evt_deliver(evt_deliver),
        .ret_legacy(ret_legacy), .ret_frame(ret_frame), .ret_lvl(ret_lvl),
        .frame_clr(frame_clr), .res_valid(res_valid), .res_retire(res_retire),
        .res_fault(res_fault), .res_kind(res_kind), .wait_bits(wait_bits),
        .frame_bit(frame_bit), .user_save(user_save)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " retire"}, int'(res_retire), int'(e.retire));
                chk({e.req, " fault"},  int'(res_fault),  int'(e.fault));
                chk({e.req, " kind"},   int'(res_kind),   int'(e.kind));
            end
        end
    end

    task automatic insn(input logic [2:0] k, input logic r, input logic f,
                        input logic [1:0] fk, input string req);
        exp_t e;
        e.retire = r; e.fault = f; e.kind = fk; e.req = req;
        exp_q.push_back(e);
        insn_kind  = k;
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic deliver(input logic with_insn, input logic clr);
        evt_deliver = 1'b1;
        insn_valid  = with_insn;
        insn_kind   = 3'd1;
        frame_clr   = clr;
        @(negedge clk);
        evt_deliver = 1'b0;
        insn_valid  = 1'b0;
        frame_clr   = 1'b0;
    endtask

    task automatic do_ret(input logic frame, input logic lvl);
        ret_frame  = frame;
        ret_legacy = ~frame;
        ret_lvl    = lvl;
        @(negedge clk);
        ret_frame  = 1'b0;
        ret_legacy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 wait_bits", int'(wait_bits), 0);
        chk("R1 frame_bit", int'(frame_bit), 0);
        chk("R1 user_save", int'(user_save), 0);

        // supervisor, 64-bit mode
        insn(3'd1, 1, 0, 0, "R2");         chk("R2 bit set", int'(wait_bits), 2);
        insn(3'd4, 1, 0, 0, "R3 pad");     chk("R3 cleared", int'(wait_bits), 0);
        insn(3'd0, 1, 0, 0, "R3 other");   chk("R3 stays 0", int'(wait_bits), 0);
        insn(3'd2, 1, 0, 0, "R4");         chk("R4 untracked", int'(wait_bits), 0);

        insn(3'd1, 1, 0, 0, "R2");
        insn(3'd0, 0, 1, 1, "R5 missing"); chk("R5 bit held", int'(wait_bits), 2);

        deliver(1'b0, 1'b0);
        chk("R7 sup armed", int'(wait_bits), 2);
        chk("R7 frame copy", int'(frame_bit), 1);
        insn(3'd4, 1, 0, 0, "R3 handler pad");
        do_ret(1'b1, 1'b1);
        chk("R9 restored", int'(wait_bits), 2);
        insn(3'd0, 0, 1, 1, "R9 refault");

        deliver(1'b0, 1'b0);
        insn(3'd4, 1, 0, 0, "R3 handler pad");
        frame_clr = 1'b1; @(negedge clk); frame_clr = 1'b0;
        chk("R10 cleared", int'(frame_bit), 0);
        do_ret(1'b1, 1'b1);
        chk("R9 restored 0", int'(wait_bits), 0);
        insn(3'd0, 1, 0, 0, "R9 resumes");

        mode64 = 1'b0;
        insn(3'd1, 1, 0, 0, "R2");
        insn(3'd4, 0, 1, 2, "R6 wrong width");
        chk("R6 bit held", int'(wait_bits), 2);
        insn(3'd3, 1, 0, 0, "R6 right pad");
        chk("R6 cleared", int'(wait_bits), 0);
        mode64 = 1'b1;

        cur_lvl = 1'b0;
        insn(3'd1, 1, 0, 0, "R11 user branch");
        chk("R11 only user bit", int'(wait_bits), 1);
        deliver(1'b1, 1'b0);
        chk("R7 both bits", int'(wait_bits), 3);
        chk("R7 frame copy", int'(frame_bit), 1);
        chk("R7 user save", int'(user_save), 1);

        cur_lvl = 1'b1;
        insn(3'd4, 1, 0, 0, "R11 handler pad");
        chk("R11 user bit kept", int'(wait_bits), 1);
        do_ret(1'b0, 1'b0);
        chk("R8 legacy clears", int'(wait_bits), 0);
        chk("R8 frame untouched", int'(frame_bit), 1);

        insn(3'd1, 1, 0, 0, "R2");
        deliver(1'b0, 1'b1);
        chk("R10 delivery wins", int'(frame_bit), 1);
        insn(3'd4, 1, 0, 0, "R3 handler pad");
        chk("R3 final clear", int'(wait_bits), 0);

        @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule